// File: doc/BRIEF.md
# Cache Block Refill Sequencer

After a cache miss, this block fills one cache block. The block holds four words. The requester presents the word address that missed and picks one of three load policies. The sequencer then fetches the needed words from the next memory level, one request at a time, over a valid/ready request channel. Each returned word is written into the line storage and its per-word valid bit is set. The missed (critical) word is also forwarded to the processor on a one-cycle response strobe as soon as it has been written, without waiting for the rest of the block.

The three policies differ only in which units are fetched and in what order:
- **Whole-block load** fetches every unit, lowest first.
- **Load-forward** fetches only from the missed unit to the top of the block.
- **Wrap-around** starts at the missed unit and wraps back to unit 0. The critical word therefore comes back first, which is where the early forward pays off most.

A new miss is taken only while the sequencer is idle. It stays busy until the last word of the chosen sequence has been written.

Top module: `refill_seq`

## Requirements
- R1: `miss_ready` is high exactly when the sequencer is idle. A `miss_valid` presented while busy is ignored: it changes neither the running refill nor its addresses, and no request is issued while idle.
- R2: With policy code 2'b00 (and also the unused code 2'b11), units 0, 1, 2 and 3 are requested in that order, whatever unit missed.
- R3: With policy code 2'b01, only units from the missed unit up to unit 3 are requested, in ascending order (a miss on unit 1 gives 1, 2, 3).
- R4: With policy code 2'b10, all four units are requested, starting at the missed unit and wrapping (a miss on unit 1 gives 1, 2, 3, 0).
- R5: A request address is the miss address with its two low bits replaced by the unit index. The low two bits of `miss_addr` select the missed unit. A request that is not accepted holds its valid and address stable.
- R6: At most one request is outstanding. After a request is accepted, `mem_req_valid` stays low until its response returns. A `mem_rsp_valid` with no request outstanding is ignored.
- R7: Accepting a miss clears all of `line_valid`. A returned word is written at its unit position in `line_words` (unit k at bits k*WORD_W upward) and sets `line_valid[k]`. Under load-forward, units below the missed unit stay invalid.
- R8: `cpu_rsp_valid` pulses for exactly one cycle per miss, in the cycle after the missed word returns, with `cpu_rsp_data` equal to that word. This holds under every policy, not only at the end of the refill.
- R9: `busy` rises in the cycle after a miss is accepted and falls in the cycle after the last word of the sequence returns.
- R10: During reset, `busy`, `mem_req_valid`, `cpu_rsp_valid` and `line_valid` are all 0, and `miss_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss request strobe |
| miss_ready | output | 1 | High when a miss can be accepted (idle) |
| miss_addr | input | ADDR_W | Word address that missed |
| miss_policy | input | 2 | Load policy: 00 block, 01 forward, 10 wrap |
| busy | output | 1 | Refill in progress |
| mem_req_valid | output | 1 | Word request to next level valid |
| mem_req_ready | input | 1 | Next level accepts the request |
| mem_req_addr | output | ADDR_W | Requested word address |
| mem_rsp_valid | input | 1 | Returned word valid |
| mem_rsp_data | input | WORD_W | Returned word |
| line_valid | output | NUM_WORDS | Per-word valid bits of the line |
| line_words | output | NUM_WORDS*WORD_W | Line contents, unit k at bits k*WORD_W |
| cpu_rsp_valid | output | 1 | Critical word strobe to the processor |
| cpu_rsp_data | output | WORD_W | Critical word |

## Verification
The bench builds the block with NUM_WORDS=4, WORD_W=16 and ADDR_W=12. This makes every miss position under every policy code, including the unused code, cheap to sweep one by one. The narrow address also lets the block-base arithmetic be checked next to the top of the address space.

Two memory behaviours are used. One is always ready. The other stalls and adds response latency at random while also throwing spurious response strobes. This exercises the hold rule on requests and the rule that a response needs an outstanding request.

Misses are re-presented while the sequencer is busy, to show they are refused. Because of that, a load-forward miss on unit 3 (a one-word refill) is the shortest case the busy window has to cover.

// File: rtl/refill_pkg.sv
package refill_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } fsm_state_t;

  localparam logic [1:0] POL_BLOCK   = 2'b00;
  localparam logic [1:0] POL_FORWARD = 2'b01;
  localparam logic [1:0] POL_WRAP    = 2'b10;

  // First unit fetched for a policy (R2, R3, R4)
  function automatic int unsigned first_unit(logic [1:0] pol, int unsigned miss);
    return (pol == POL_FORWARD || pol == POL_WRAP) ? miss : 0;
  endfunction

  // Number of words fetched for a policy (R3 shortens the burst)
  function automatic int unsigned burst_len(logic [1:0] pol, int unsigned miss,
                                            int unsigned n);
    return (pol == POL_FORWARD) ? n - miss : n;
  endfunction

  // Next unit, wrapping at the block end (R4)
  function automatic int unsigned step_unit(int unsigned cur, int unsigned n);
    return (cur + 1 == n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/refill_order.sv
module refill_order
  import refill_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [1:0]       pol,
  input  logic [IDX_W-1:0] miss_unit,
  input  logic             advance,
  output logic [IDX_W-1:0] cur_unit,
  output logic             last_unit
);
  localparam int CNT_W = IDX_W + 1;

  logic [IDX_W-1:0] cur_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      cur_q  <= IDX_W'(first_unit(pol, int'(miss_unit)));
      left_q <= CNT_W'(burst_len(pol, int'(miss_unit), NUM_WORDS));
    end else if (advance) begin
      cur_q  <= IDX_W'(step_unit(int'(cur_q), NUM_WORDS));
      left_q <= left_q - CNT_W'(1);
    end
  end

  assign cur_unit  = cur_q;
  assign last_unit = (left_q == CNT_W'(1));
endmodule

// File: rtl/refill_line_store.sv
module refill_line_store #(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 32,
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_unit,
  input  logic [WORD_W-1:0]           wr_data,
  output logic [NUM_WORDS-1:0]        word_valid,
  output logic [NUM_WORDS*WORD_W-1:0] words
);
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic              v_q;
    logic [WORD_W-1:0] d_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else if (clear) begin
        v_q <= 1'b0;
      end else if (wr_en && wr_unit == IDX_W'(g)) begin
        v_q <= 1'b1;
        d_q <= wr_data;
      end
    end

    assign word_valid[g]              = v_q;
    assign words[g*WORD_W +: WORD_W]  = d_q;
  end
endmodule

// File: rtl/refill_fsm.sv
module refill_fsm
  import refill_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic miss_valid,
  input  logic req_ready,
  input  logic rsp_valid,
  input  logic last_unit,
  output logic miss_ready,
  output logic start,
  output logic req_valid,
  output logic wr_en,
  output logic advance,
  output logic busy
);
  fsm_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (miss_valid) st_d = ST_ISSUE;
      ST_ISSUE: if (req_ready)  st_d = ST_WAIT;
      ST_WAIT:  if (rsp_valid)  st_d = last_unit ? ST_IDLE : ST_ISSUE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign miss_ready = (st_q == ST_IDLE);
  assign start      = miss_ready && miss_valid;
  assign req_valid  = (st_q == ST_ISSUE);
  assign wr_en      = (st_q == ST_WAIT) && rsp_valid;
  assign advance    = wr_en && !last_unit;
  assign busy       = !miss_ready;
endmodule

// File: rtl/refill_seq.sv
module refill_seq
  import refill_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        miss_valid,
  output logic                        miss_ready,
  input  logic [ADDR_W-1:0]           miss_addr,
  input  logic [1:0]                  miss_policy,
  output logic                        busy,
  output logic                        mem_req_valid,
  input  logic                        mem_req_ready,
  output logic [ADDR_W-1:0]           mem_req_addr,
  input  logic                        mem_rsp_valid,
  input  logic [WORD_W-1:0]           mem_rsp_data,
  output logic [NUM_WORDS-1:0]        line_valid,
  output logic [NUM_WORDS*WORD_W-1:0] line_words,
  output logic                        cpu_rsp_valid,
  output logic [WORD_W-1:0]           cpu_rsp_data
);
  localparam int IDX_W  = $clog2(NUM_WORDS);
  localparam int BASE_W = ADDR_W - IDX_W;

  // Named internal events (observed by the checker)
  logic             ev_accept;
  logic             ev_issue;
  logic             ev_return;
  logic             ev_critical;
  logic             ev_advance;
  logic             last_unit;
  logic [IDX_W-1:0] cur_unit;

  logic [BASE_W-1:0] base_q;
  logic [IDX_W-1:0]  miss_unit_q;
  logic              cpu_v_q;
  logic [WORD_W-1:0] cpu_d_q;

  refill_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .req_ready  (mem_req_ready),
    .rsp_valid  (mem_rsp_valid),
    .last_unit  (last_unit),
    .miss_ready (miss_ready),
    .start      (ev_accept),
    .req_valid  (mem_req_valid),
    .wr_en      (ev_return),
    .advance    (ev_advance),
    .busy       (busy)
  );

  refill_order #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_order (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_accept),
    .pol       (miss_policy),
    .miss_unit (miss_addr[IDX_W-1:0]),
    .advance   (ev_advance),
    .cur_unit  (cur_unit),
    .last_unit (last_unit)
  );

  refill_line_store #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (ev_accept),
    .wr_en      (ev_return),
    .wr_unit    (cur_unit),
    .wr_data    (mem_rsp_data),
    .word_valid (line_valid),
    .words      (line_words)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q      <= '0;
      miss_unit_q <= '0;
    end else if (ev_accept) begin
      base_q      <= miss_addr[ADDR_W-1:IDX_W];
      miss_unit_q <= miss_addr[IDX_W-1:0];
    end
  end

  assign ev_issue    = mem_req_valid && mem_req_ready;
  assign ev_critical = ev_return && (cur_unit == miss_unit_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_v_q <= 1'b0;
      cpu_d_q <= '0;
    end else begin
      cpu_v_q <= ev_critical;
      if (ev_critical) cpu_d_q <= mem_rsp_data;
    end
  end

  assign mem_req_addr  = {base_q, cur_unit};
  assign cpu_rsp_valid = cpu_v_q;
  assign cpu_rsp_data  = cpu_d_q;
endmodule

// File: rtl/refill_seq_chk.sv
module refill_seq_chk #(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 miss_valid,
  input logic                 miss_ready,
  input logic                 busy,
  input logic                 mem_req_valid,
  input logic                 mem_req_ready,
  input logic [ADDR_W-1:0]    mem_req_addr,
  input logic [WORD_W-1:0]    mem_rsp_data,
  input logic                 ev_issue,
  input logic                 ev_return,
  input logic                 ev_critical,
  input logic [IDX_W-1:0]     cur_unit,
  input logic [NUM_WORDS-1:0] line_valid,
  input logic                 cpu_rsp_valid,
  input logic [WORD_W-1:0]    cpu_rsp_data
);
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R5
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    ev_issue |=> !mem_req_valid); // R6
  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && miss_ready |=> line_valid == '0); // R7
  AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ev_return |=> line_valid[$past(cur_unit)]); // R7
  AST_CRIT_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_critical |=> cpu_rsp_valid && cpu_rsp_data == $past(mem_rsp_data)); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid); // R8
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && miss_ready |=> busy); // R9
endmodule

bind refill_seq refill_seq_chk #(
  .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .miss_valid    (miss_valid),
  .miss_ready    (miss_ready),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_data  (mem_rsp_data),
  .ev_issue      (ev_issue),
  .ev_return     (ev_return),
  .ev_critical   (ev_critical),
  .cur_unit      (cur_unit),
  .line_valid    (line_valid),
  .cpu_rsp_valid (cpu_rsp_valid),
  .cpu_rsp_data  (cpu_rsp_data)
);

// File: tb/refill_seq_bench.sv
module refill_seq_bench;
  localparam int NW = 4;
  localparam int WW = 16;
  localparam int AW = 12;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              miss_valid = 1'b0;
  logic [AW-1:0]     miss_addr = '0;
  logic [1:0]        miss_policy = 2'b00;
  logic              mem_req_ready = 1'b0;
  logic              mem_rsp_valid = 1'b0;
  logic [WW-1:0]     mem_rsp_data = '0;
  logic              miss_ready, busy, mem_req_valid, cpu_rsp_valid;
  logic [AW-1:0]     mem_req_addr;
  logic [NW-1:0]     line_valid;
  logic [NW*WW-1:0]  line_words;
  logic [WW-1:0]     cpu_rsp_data;

  refill_seq #(.NUM_WORDS(NW), .WORD_W(WW), .ADDR_W(AW)) u_refill_seq (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_addr(miss_addr), .miss_policy(miss_policy), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .line_valid(line_valid), .line_words(line_words),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_data(cpu_rsp_data)
  );

  int checks = 0;
  int fails  = 0;
  bit cmp_en = 0;
  bit stall_mode = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string order_tag(logic [1:0] p);
    if (p == 2'b01) return "R3";
    if (p == 2'b10) return "R4";
    return "R2";
  endfunction

  function automatic logic [WW-1:0] mem_word(logic [AW-1:0] a);
    return WW'(a) * 16'd40503 + 16'h5A3C;
  endfunction

  // Behavioural reference model, updated at each rising edge
  bit            m_busy = 0, m_out = 0, m_cpu_v = 0;
  logic [WW-1:0] m_cpu_d = '0;
  logic [NW-1:0] m_valid = '0;
  logic [WW-1:0] m_data [NW];
  int            q[$];
  int            m_miss = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_pol = 2'b00;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_out = 0; m_cpu_v = 0; m_valid = '0; q.delete();
    end else begin
      m_cpu_v = 0;
      if (!m_busy) begin
        if (miss_valid) begin
          m_busy = 1; m_out = 0; m_valid = '0; m_pol = miss_policy;
          m_miss = int'(miss_addr[IW-1:0]);
          m_base = {miss_addr[AW-1:IW], 2'b00};
          q.delete();
          if (miss_policy == 2'b01)
            for (int u = m_miss; u < NW; u++) q.push_back(u);
          else if (miss_policy == 2'b10)
            for (int k = 0; k < NW; k++) q.push_back((m_miss + k) % NW);
          else
            for (int u = 0; u < NW; u++) q.push_back(u);
        end
      end else if (!m_out) begin
        if (mem_req_ready) m_out = 1;
      end else if (mem_rsp_valid) begin
        int u;
        u = q.pop_front();
        m_valid[u] = 1'b1;
        m_data[u]  = mem_rsp_data;
        if (u == m_miss) begin
          m_cpu_v = 1; m_cpu_d = mem_rsp_data;
        end
        m_out = 0;
        if (q.size() == 0) m_busy = 0;
      end
    end
  end

  // Compare outputs against the model away from the active edge
  int d_cpu = 0;
  int d_iss = 0;
  always @(negedge clk) begin
    if (cmp_en) begin
      chk(busy === m_busy, "R9", "busy", busy, m_busy);
      chk(miss_ready === !m_busy, "R1", "miss_ready", miss_ready, !m_busy);
      chk(mem_req_valid === (m_busy && !m_out), "R6", "mem_req_valid",
          mem_req_valid, m_busy && !m_out);
      if (m_busy && !m_out && q.size() > 0)
        chk(mem_req_addr === (m_base | AW'(q[0])), order_tag(m_pol), "mem_req_addr (R5)",
            mem_req_addr, m_base | AW'(q[0]));
      chk(line_valid === m_valid, "R7", "line_valid", line_valid, m_valid);
      for (int u = 0; u < NW; u++)
        if (m_valid[u])
          chk(line_words[u*WW +: WW] === m_data[u], "R7", "line word",
              line_words[u*WW +: WW], m_data[u]);
      chk(cpu_rsp_valid === m_cpu_v, "R8", "cpu_rsp_valid", cpu_rsp_valid, m_cpu_v);
      if (m_cpu_v)
        chk(cpu_rsp_data === m_cpu_d, "R8", "cpu_rsp_data", cpu_rsp_data, m_cpu_d);
      if (cpu_rsp_valid) d_cpu++;
    end
  end

  // Next-level memory: one response per accepted request, optional stalls
  bit            pend = 0;
  int            lat = 0;
  logic [AW-1:0] pend_addr = '0;
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (pend) begin
      if (lat == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(pend_addr);
        pend = 0;
      end else lat--;
    end else if (stall_mode && ($urandom % 3 == 0)) begin
      mem_rsp_valid = 1'b1;            // spurious, no request outstanding (R6)
      mem_rsp_data  = WW'($urandom);
    end
    mem_req_ready = stall_mode ? ($urandom % 2 == 0) : 1'b1;
    if (rst_n && mem_req_ready && mem_req_valid && !pend) begin
      pend = 1;
      pend_addr = mem_req_addr;
      lat = stall_mode ? int'($urandom % 3) : 0;
      d_iss++;
    end
  end

  task automatic do_miss(logic [AW-1:0] addr, logic [1:0] pol);
    int exp_len;
    exp_len = (pol == 2'b01) ? NW - int'(addr[IW-1:0]) : NW;
    d_cpu = 0; d_iss = 0;
    @(negedge clk);
    miss_valid = 1'b1; miss_addr = addr; miss_policy = pol;
    @(negedge clk);
    miss_valid = 1'b1; miss_addr = ~addr; miss_policy = pol ^ 2'b11; // R1 poke while busy
    @(negedge clk);
    miss_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(d_cpu == 1, "R8", "critical strobes per miss", d_cpu, 1);
    chk(d_iss == exp_len, order_tag(pol), "request count", d_iss, exp_len);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R10", "busy in reset", busy, 0);
    chk(miss_ready === 1'b1, "R10", "miss_ready in reset", miss_ready, 1);
    chk(mem_req_valid === 1'b0, "R10", "mem_req_valid in reset", mem_req_valid, 0);
    chk(cpu_rsp_valid === 1'b0, "R10", "cpu_rsp_valid in reset", cpu_rsp_valid, 0);
    chk(line_valid === '0, "R10", "line_valid in reset", line_valid, 0);
    rst_n = 1'b1;
    cmp_en = 1;
    for (int s = 0; s < 2; s++) begin
      stall_mode = (s == 1);
      for (int p = 0; p < 4; p++)
        for (int u = 0; u < NW; u++)
          do_miss({AW-IW{1'b0}} | AW'((p * 37 + s * 11 + 5) << IW) | AW'(u), 2'(p));
    end
    do_miss({{(AW-IW){1'b1}}, 2'b10}, 2'b10);
    do_miss({{(AW-IW){1'b1}}, 2'b11}, 2'b01);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R9 actual=busy expected=idle");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule